// File: doc/BRIEF.md
# Cascadable Synchronous Binary Counter

The block is a synchronous up-counter built from identical 4-bit slices. Each slice chooses one of four actions on every rising clock edge, in fixed priority: clear to zero, parallel load from the data word, count up by one, or hold. Clear and load are active low and synchronous, and they take effect whatever the count enables are doing. Counting needs two enables to be high together. One is common to every slice. The other is a carry enable that also gates the slice's terminal-count output.

A parameterised wrapper chains NSLICE slices into a counter that is 4*NSLICE bits wide. Clear, load and the common enable are shared by all slices. The terminal-count output of each slice drives the carry enable of the slice above it. The terminal-count output of the top slice is the wrapper's carry-out. Driving the clear input from a decode of the value just below a chosen modulus M gives a modulo-M counter.

Top module: `cnt_chain`

## Requirements
- R1: When clear_n is low at a rising edge, count becomes all zeros on that edge, whatever load_n, cep, cet and din are.
- R2: When load_n is low and clear_n is high at a rising edge, count takes the value of din on that edge, whatever cep and cet are.
- R3: When clear_n, load_n, cep and cet are all high at a rising edge, count increases by exactly one across its full width. Carries pass between slices in the same edge.
- R4: When clear_n and load_n are high and either cep or cet is low at a rising edge, count keeps its value.
- R5: tc is combinational and equals cet AND (every bit of count is 1). It is low whenever cet is low, and cep has no effect on it.
- R6: Counting from the all-ones value returns count to all zeros on the next enabled edge.
- R7: If clear_n is driven low exactly while count equals M-1, and the counter is otherwise counting, count repeats 0, 1, ..., M-1.
- R8: count changes only at rising clock edges. Between edges it does not follow changes of the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every state update happens on its rising edge |
| clear_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| cep | input | 1 | Count enable common to all slices |
| cet | input | 1 | Carry enable into the lowest slice; also gates tc |
| din | input | 4*NSLICE | Parallel load data |
| count | output | 4*NSLICE | Counter value |
| tc | output | 1 | Terminal count / carry-out of the top slice |

## Verification
count is registered, so clear, load, count and hold results (R1–R4, R6, R7) are due on the first rising edge after the inputs are set. The bench drives inputs on the falling edge and compares count on the following falling edge, which is one edge after the update it expects. tc has no register in its path (R5), so the bench compares it shortly after each input change and before the next rising edge. For R8 it also samples count after an input change that comes between edges.

// File: rtl/cnt_pkg.sv
// Package: shared widths and the per-slice action type for the counter.
package cnt_pkg;
    localparam int SLICE_W = 4;

    typedef logic [SLICE_W-1:0] nib_t;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } op_e;
endpackage

// File: rtl/cnt_op_decode.sv
// cnt_op_decode: picks the slice action from the control pins.
// Priority: clear, then load, then count (needs both enables), then hold.
// Assumes the control inputs meet setup to the clock of the slice that uses op.
module cnt_op_decode
    import cnt_pkg::*;
(
    input  logic clear_n,
    input  logic load_n,
    input  logic cep,
    input  logic cet,
    output op_e  op
);
    // Purpose: fixed-priority selection of the next action.
    always_comb begin
        if (!clear_n)         op = OP_CLEAR;
        else if (!load_n)     op = OP_LOAD;
        else if (cep && cet)  op = OP_COUNT;
        else                  op = OP_HOLD;
    end
endmodule

// File: rtl/cnt_slice.sv
// cnt_slice: one 4-bit counter stage with synchronous clear and load.
// tc is high when cet is high and the stage holds its all-ones value.
// Assumes a single clock; no asynchronous reset (clear_n is synchronous).
module cnt_slice
    import cnt_pkg::*;
(
    input  logic clk,
    input  logic clear_n,
    input  logic load_n,
    input  logic cep,
    input  logic cet,
    input  nib_t d,
    output nib_t q,
    output logic tc
);
    op_e  op;
    nib_t q_nxt;

    cnt_op_decode u_dec (
        .clear_n (clear_n),
        .load_n  (load_n),
        .cep     (cep),
        .cet     (cet),
        .op      (op)
    );

    // Purpose: next-state value for the chosen action.
    always_comb begin
        unique case (op)
            OP_CLEAR: q_nxt = '0;
            OP_LOAD:  q_nxt = d;
            OP_COUNT: q_nxt = q + nib_t'(1);
            default:  q_nxt = q;
        endcase
    end

    // Purpose: state register, updated only on the rising edge.
    always_ff @(posedge clk) begin
        q <= q_nxt;
    end

    // Purpose: terminal count, gated by the carry enable only.
    assign tc = cet & (&q);
endmodule

// File: rtl/cnt_chain.sv
// cnt_chain: NSLICE counter slices joined into one wide counter.
// Clear, load and cep are common; each slice's tc feeds the next cet.
// Assumes NSLICE >= 1; the top slice's tc is the carry-out.
module cnt_chain
    import cnt_pkg::*;
#(
    parameter int NSLICE = 2,
    localparam int W = NSLICE * SLICE_W
) (
    input  logic         clk,
    input  logic         clear_n,
    input  logic         load_n,
    input  logic         cep,
    input  logic         cet,
    input  logic [W-1:0] din,
    output logic [W-1:0] count,
    output logic         tc
);
    logic [NSLICE:0] carry;

    assign carry[0] = cet;

    for (genvar i = 0; i < NSLICE; i++) begin : g_slice
        cnt_slice u_slice (
            .clk     (clk),
            .clear_n (clear_n),
            .load_n  (load_n),
            .cep     (cep),
            .cet     (carry[i]),
            .d       (din[i*SLICE_W +: SLICE_W]),
            .q       (count[i*SLICE_W +: SLICE_W]),
            .tc      (carry[i+1])
        );
    end

    assign tc = carry[NSLICE];
endmodule

// File: rtl/cnt_chain_chk.sv
// cnt_chain_chk: property checker for cnt_chain, bound below.
// Arms after the first edge that sees clear_n low, so the count is known.
module cnt_chain_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         clear_n,
    input logic         load_n,
    input logic         cep,
    input logic         cet,
    input logic [W-1:0] din,
    input logic [W-1:0] count,
    input logic         tc
);
    logic armed = 1'b0;

    // Purpose: mark that a clear has defined the state.
    always_ff @(posedge clk) begin
        armed <= armed | ~clear_n;
    end

    p_clear_zero_r1: assert property (@(posedge clk) disable iff (!armed)
        !clear_n |=> count == '0);

    p_load_data_r2: assert property (@(posedge clk) disable iff (!armed)
        (clear_n && !load_n) |=> count == $past(din));

    p_step_one_r3: assert property (@(posedge clk) disable iff (!armed)
        (clear_n && load_n && cep && cet) |=> count == W'($past(count) + 1'b1));

    p_hold_r4: assert property (@(posedge clk) disable iff (!armed)
        (clear_n && load_n && !(cep && cet)) |=> $stable(count));

    p_tc_value_r5: assert property (@(posedge clk) disable iff (!armed)
        tc == (cet && (count == {W{1'b1}})));

    p_tc_gated_r5: assert property (@(posedge clk) disable iff (!armed)
        !cet |-> !tc);

    p_wrap_r6: assert property (@(posedge clk) disable iff (!armed)
        (clear_n && load_n && cep && cet && (count == {W{1'b1}})) |=> count == '0);
endmodule

bind cnt_chain cnt_chain_chk #(.W(W)) u_chk (
    .clk     (clk),
    .clear_n (clear_n),
    .load_n  (load_n),
    .cep     (cep),
    .cet     (cet),
    .din     (din),
    .count   (count),
    .tc      (tc)
);

// File: tb/cnt_chain_bench.sv
`timescale 1ns/1ps
module cnt_chain_bench;
    localparam int NSLICE = 2;
    localparam int W      = 4 * NSLICE;
    localparam int MODV   = 1 << W;

    logic         clk = 1'b0;
    logic         clear_n = 1'b1, load_n = 1'b1, cep = 1'b0, cet = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] count;
    logic         tc;

    int vectors = 0;
    int fails   = 0;
    int ref_cnt = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    cnt_chain #(.NSLICE(NSLICE)) u_cnt_chain (
        .clk(clk), .clear_n(clear_n), .load_n(load_n), .cep(cep),
        .cet(cet), .din(din), .count(count), .tc(tc)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    // One cycle: drive at the falling edge, check tc before the rise,
    // update the model at the rise, check count at the next falling edge.
    task automatic step(input bit c_n, input bit l_n, input bit p, input bit t,
                        input int d, input string req);
        clear_n = c_n; load_n = l_n; cep = p; cet = t; din = W'(d);
        #1;
        chk("R5 tc", int'(tc), int'(t && ref_cnt == MODV - 1));
        @(posedge clk);
        if (!c_n)          ref_cnt = 0;
        else if (!l_n)     ref_cnt = d % MODV;
        else if (p && t)   ref_cnt = (ref_cnt + 1) % MODV;
        @(negedge clk);
        chk(req, int'(count), ref_cnt);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: clear wins over load and both enables
        step(1'b0, 1'b0, 1'b1, 1'b1, 8'h5A, "R1 clear priority");
        // R2: load with both enables low, then with both high
        step(1'b1, 1'b0, 1'b0, 1'b0, 8'hA5, "R2 load enables low");
        step(1'b1, 1'b0, 1'b1, 1'b1, 8'h0E, "R2 load enables high");
        // R3: counting across the slice boundary (0E -> 0F -> 10 -> 11)
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, 1'b1, 0, "R3 increment");
        // R4: hold with cep low, then with cet low
        step(1'b1, 1'b1, 1'b0, 1'b1, 0, "R4 hold cep low");
        step(1'b1, 1'b1, 1'b1, 1'b0, 0, "R4 hold cet low");
        // R5: at all ones, tc follows cet, ignores cep
        step(1'b1, 1'b0, 1'b0, 1'b0, MODV - 1, "R2 load all ones");
        step(1'b1, 1'b1, 1'b0, 1'b1, 0, "R5 cep low tc high");
        step(1'b1, 1'b1, 1'b1, 1'b0, 0, "R5 cet low tc low");
        // R6: wrap to zero
        step(1'b1, 1'b1, 1'b1, 1'b1, 0, "R6 wrap");
        // R8: input change between edges leaves count unchanged
        clear_n = 1'b0; load_n = 1'b0; din = 8'h33; #3;
        chk("R8 no change between edges", int'(count), ref_cnt);
        clear_n = 1'b1; load_n = 1'b1;
        // R7: modulo-10 via clear decoded from value 9
        step(1'b0, 1'b1, 1'b1, 1'b1, 0, "R1 clear before modulo");
        for (int i = 0; i < 35; i++) begin
            bit at_top;
            int exp_next;
            at_top   = (int'(count) == 9);
            exp_next = at_top ? 0 : int'(count) + 1;
            step(!at_top, 1'b1, 1'b1, 1'b1, 0, "R7 modulo step");
            chk("R7 modulo sequence", int'(count), exp_next);
        end
        // Mixed stimulus against the model
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            step(r >= 3, !(r >= 3 && r < 8), $urandom_range(0, 9) != 0,
                 $urandom_range(0, 9) != 0, int'($urandom_range(0, MODV - 1)),
                 "R3 mixed stimulus");
        end
        done = 1'b1;
        summary();
        $finish;
    end
endmodule